// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a host an 8-bit path into a bank of 64 internal registers through a single control address. The host issues write and read strobes against that address. A two-phase sequencer decides whether each write is a register pointer or a data byte. The first write of a pair selects the register. The second write stores into it. A read returns the currently selected register and always puts the sequencer back into the pointer phase. Software can therefore resynchronise with the port without knowing what happened before.

Bit 0 of register 0 is a device reset flag. The port comes out of hardware reset with this flag set. Setting the flag clears every other register. While the flag is set, pointer handling is suspended: every write lands in register 0 and every read returns register 0. A write with bit 0 low brings the port out of reset in the pointer phase.

The six-access sequence read, write 0x00, read, write 0x00, write 0x01, write 0x00 therefore always ends with the flag clear and the port in the pointer phase, from any starting condition.

Top module: `indirect_access_port`

## Requirements
- R1: After hardware reset (synchronous, active-high `rst`), `dev_in_reset` is 1 and a read returns 0x01.
- R2: In the pointer phase, a write takes the pointer from host_wdata bits 5:0 and ignores bits 7:6. The port then enters the data phase.
- R3: In the data phase, a write stores host_wdata into the pointed register and returns the port to the pointer phase.
- R4: After a read strobe, host_rdata holds the pointed register in the following cycle. The read leaves the pointer unchanged.
- R5: A read in the data phase abandons the pending data write. The next write is taken as a pointer.
- R6: When a read and a write strobe arrive in the same cycle, the read is served and the write has no effect.
- R7: A data write to register 0 with bit 0 set puts the port in reset: `dev_in_reset` goes to 1 and registers 1 to 63 are cleared.
- R8: While in reset, every write goes to register 0 and the pointer is forced to 0. A written byte with bit 0 low ends the reset state, and the port is then in the pointer phase.
- R9: While in reset, a read returns register 0.
- R10: The sequence read, write 0x00, read, write 0x00, write 0x01, write 0x00 leaves `dev_in_reset` at 0 and the port in the pointer phase. This holds from the pointer phase, from the data phase and from the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after host_rd |
| dev_in_reset | output | 1 | Current value of the reset flag (register 0 bit 0) |

## Verification
Write pairs use pointers with bits 7:6 set, which shows whether the upper bits are truly ignored. An aborted pair, meaning pointer, read, pointer, data, shows whether a read resets the phase or only returns data. Simultaneous strobes and writes made during reset show whether data goes to the pointed register or is forced to register 0. The recovery sequence is applied from the pointer phase, from the data phase and from the reset state. A final pair and read then proves that the port ended in the pointer phase with the flag clear.

// File: rtl/iap_pkg.sv
package iap_pkg;

    typedef enum logic {
        PH_PTR  = 1'b0,
        PH_DATA = 1'b1
    } iap_phase_e;

    localparam int RST_FLAG_BIT = 0;

    function automatic logic sets_reset(input logic [7:0] value);
        return value[RST_FLAG_BIT];
    endfunction

endpackage

// File: rtl/iap_sequencer.sv
module iap_sequencer
    import iap_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  logic             in_reset,
    input  logic [PTR_W-1:0] ptr_in,
    output logic             data_we,
    output logic [PTR_W-1:0] data_addr,
    output logic             rd_en,
    output logic [PTR_W-1:0] rd_addr,
    output iap_phase_e       phase
);

    logic [PTR_W-1:0] ptr_q;
    logic             wr_eff;

    assign wr_eff = wr && !rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_PTR;
            ptr_q <= '0;
        end else if (rd) begin
            phase <= PH_PTR;
        end else if (wr) begin
            if (in_reset) begin
                phase <= PH_PTR;
                ptr_q <= '0;
            end else if (phase == PH_PTR) begin
                ptr_q <= ptr_in;
                phase <= PH_DATA;
            end else begin
                phase <= PH_PTR;
            end
        end
    end

    always_comb begin
        data_we   = wr_eff && (in_reset || phase == PH_DATA);
        data_addr = in_reset ? '0 : ptr_q;
        rd_en     = rd;
        rd_addr   = in_reset ? '0 : ptr_q;
    end

    p_rd_resync_r5: assert property (@(posedge clk) disable iff (rst)
        rd |=> phase == PH_PTR);

    p_ptr_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_eff && !in_reset && phase == PH_PTR)
        |=> (phase == PH_DATA && ptr_q == $past(ptr_in)));

    p_data_return_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_eff && !in_reset && phase == PH_DATA) |=> phase == PH_PTR);

    p_reset_ptr_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_eff && in_reset) |=> (ptr_q == '0 && phase == PH_PTR));

    p_rd_keeps_ptr_r4: assert property (@(posedge clk) disable iff (rst)
        rd |=> $stable(ptr_q));

endmodule

// File: rtl/iap_bank.sv
module iap_bank
    import iap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_flag
);

    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] entries [DEPTH];
    logic              enter_rst;
    logic              others_nz;

    assign enter_rst = we && (waddr == '0) && wdata[RST_FLAG_BIT];
    assign rst_flag  = entries[0][RST_FLAG_BIT];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        if (g == 0) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (rst)
                    entries[g] <= DATA_W'(1) << RST_FLAG_BIT;
                else if (we && waddr == PTR_W'(g))
                    entries[g] <= wdata;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst || enter_rst)
                    entries[g] <= '0;
                else if (we && waddr == PTR_W'(g))
                    entries[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (re)
            rdata <= entries[raddr];
    end

    always_comb begin
        others_nz = 1'b0;
        for (int i = 1; i < DEPTH; i++)
            others_nz = others_nz | (|entries[i]);
    end

    p_reset_clears_r7: assert property (@(posedge clk) disable iff (rst)
        rst_flag |-> !others_nz);

    p_reset_entry_r7: assert property (@(posedge clk) disable iff (rst)
        enter_rst |=> rst_flag);

endmodule

// File: rtl/indirect_access_port.sv
module indirect_access_port
    import iap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              dev_in_reset
);

    logic             data_we;
    logic [PTR_W-1:0] data_addr;
    logic             rd_en;
    logic [PTR_W-1:0] rd_addr;
    logic             rst_flag;
    iap_phase_e       phase;

    iap_sequencer #(.PTR_W(PTR_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .wr        (host_wr),
        .rd        (host_rd),
        .in_reset  (rst_flag),
        .ptr_in    (host_wdata[PTR_W-1:0]),
        .data_we   (data_we),
        .data_addr (data_addr),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .phase     (phase)
    );

    iap_bank #(.DATA_W(DATA_W), .PTR_W(PTR_W)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .we       (data_we),
        .waddr    (data_addr),
        .wdata    (host_wdata),
        .re       (rd_en),
        .raddr    (rd_addr),
        .rdata    (host_rdata),
        .rst_flag (rst_flag)
    );

    assign dev_in_reset = rst_flag;

    p_rd_in_reset_r9: assert property (@(posedge clk) disable iff (rst)
        (host_rd && rst_flag) |=> host_rdata[RST_FLAG_BIT]);

    p_both_no_store_r6: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_wr) |=> $stable(dev_in_reset));

    p_exit_reset_r8: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_rd && rst_flag && !host_wdata[RST_FLAG_BIT])
        |=> (!dev_in_reset && phase == PH_PTR));

endmodule

// File: tb/indirect_access_port_tb.sv
module indirect_access_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       dev_in_reset;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    indirect_access_port dut_i (
        .clk          (clk),
        .rst          (rst),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .dev_in_reset (dev_in_reset)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] b);
        @(negedge clk);
        host_wr = 1'b1; host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_rd(output logic [7:0] v);
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic do_both(input logic [7:0] b, output logic [7:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_wr = 1'b1; host_wdata = b;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        v = host_rdata;
    endtask

    task automatic recover();
        logic [7:0] v;
        do_rd(v);
        do_wr(8'h00);
        do_rd(v);
        do_wr(8'h00);
        do_wr(8'h01);
        do_wr(8'h00);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        check("R1 flag", {7'b0, dev_in_reset}, 8'h01);
        do_rd(v);
        check("R1 read", v, 8'h01);
        check("R9 read in reset", v, 8'h01);
        do_wr(8'h00);
        check("R8 exit", {7'b0, dev_in_reset}, 8'h00);
    endtask

    task automatic t_pair();
        logic [7:0] v;
        do_wr(8'hC5);
        do_wr(8'hA5);
        do_wr(8'h05);
        do_rd(v);
        check("R2 upper bits ignored", v, 8'hA5);
        do_rd(v);
        check("R4 pointer kept", v, 8'hA5);
        do_wr(8'h3F);
        do_wr(8'h5A);
        do_rd(v);
        check("R3 store top", v, 8'h5A);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        do_wr(8'h09);
        do_rd(v);
        do_wr(8'h0A);
        do_wr(8'h55);
        do_wr(8'h09);
        do_rd(v);
        check("R5 reg9 untouched", v, 8'h00);
        do_wr(8'h0A);
        do_rd(v);
        check("R5 reg10 stored", v, 8'h55);
    endtask

    task automatic t_both();
        logic [7:0] v;
        do_wr(8'h0B);
        do_both(8'h77, v);
        check("R6 read served", v, 8'h00);
        do_wr(8'h0B);
        do_rd(v);
        check("R6 write dropped", v, 8'h00);
    endtask

    task automatic t_enter_reset();
        logic [7:0] v;
        do_wr(8'h00);
        do_wr(8'h01);
        check("R7 flag set", {7'b0, dev_in_reset}, 8'h01);
        do_wr(8'h05);
        check("R8 stays in reset", {7'b0, dev_in_reset}, 8'h01);
        do_rd(v);
        check("R9 read reg0", v, 8'h05);
        do_wr(8'h02);
        check("R8 exit on bit0 low", {7'b0, dev_in_reset}, 8'h00);
        do_rd(v);
        check("R8 write went to reg0", v, 8'h02);
        do_wr(8'h0A);
        do_rd(v);
        check("R7 reg10 cleared", v, 8'h00);
        do_wr(8'h05);
        do_rd(v);
        check("R7 reg5 cleared", v, 8'h00);
    endtask

    task automatic probe_ptr_phase(input string tag, input logic [7:0] val);
        logic [7:0] v;
        check({tag, " flag clear"}, {7'b0, dev_in_reset}, 8'h00);
        do_wr(8'h04);
        do_wr(val);
        do_wr(8'h04);
        do_rd(v);
        check({tag, " pointer phase"}, v, val);
    endtask

    task automatic t_recovery();
        recover();
        probe_ptr_phase("R10 from ptr", 8'h99);
        do_wr(8'h03);
        recover();
        probe_ptr_phase("R10 from data", 8'h66);
        do_wr(8'h00);
        do_wr(8'h01);
        recover();
        probe_ptr_phase("R10 from reset", 8'h33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_pair();
        t_abort();
        t_both();
        t_enter_reset();
        t_recovery();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule